// File: doc/BRIEF.md
# Programmable Address Window Decoder

A bank of twenty programmable address windows that steers a 36-bit physical address to one device. Each window carries an enable, a 4-bit target ID, an 8-bit attribute, a base page and a power-of-two size counted in 64 KiB granules. Software programs the windows through a 32-bit word register port with an 8-bit byte offset. The decode side takes one address per cycle. One cycle later it reports the hit or miss, the target and attribute of the winning window, and the outgoing address.

The eight low-numbered windows can translate addresses. For these windows, the page bits that lie above the window size come from a remap base, and the offset inside the window is kept. The other twelve windows pass the address through unchanged and have no remap storage. Their register groups are packed at an 8-byte stride above a 16-byte reserved gap.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset, every register offset reads zero and every decode request reports a miss.
- R2: Window n < 8 has its register group at byte offset 16·n, with control at +0x0, base at +0x4, remap-low at +0x8 and remap-high at +0xC. Window n ≥ 8 has its group at 0x90 + 8·(n−8), with control at +0x0 and base at +0x4. Offset bits 1:0 are ignored. Each register reads back what was last written to it, masked per R3.
- R3: Control word: bit 0 is the enable, bits 7:4 the target, bits 15:8 the attribute, bits 31:16 the size minus one in 64 KiB units. Base word: bits 31:16 give address bits 31:16, and bits 3:0 give address bits 35:32. Remap-low keeps bits 31:16. Remap-high keeps bits 3:0 as translated address bits 35:32. All other bits read zero.
- R4: Writes to the reserved gap 0x80–0x8F and to offsets at or above 0xF0 change no window state. Reads there return zero.
- R5: A window whose enable bit is clear never hits. Writing zero to its control and base words disables it.
- R6: A window hits when address bits 35:16, ANDed with the inverse of the zero-extended size field, equal its 20-bit base page. An unaligned base therefore never hits.
- R7: On a hit in window n < 8, the output page is the remap page ORed with the address page bits covered by the size field, and address bits 15:0 pass through. On a hit in window n ≥ 8, and on a miss, the output address equals the input address.
- R8: When several enabled windows hit, the lowest-numbered window supplies the target, the attribute and the output address.
- R9: The decode result appears on the clock edge after `dec_valid_i` is sampled, and requests may come every cycle. When the request's valid is low: hit and miss are low, and target, attribute and address are zero. On a miss: miss is high, and target and attribute are zero.
- R10: A register write affects decodes sampled from the next clock edge onward. A decode sampled on the same edge as the write uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, same cycle |
| dec_valid_i | input | 1 | Decode request valid |
| dec_addr_i | input | 36 | Address to decode |
| dec_valid_o | output | 1 | Decode result valid |
| dec_hit_o | output | 1 | A window matched |
| dec_miss_o | output | 1 | Valid request with no matching window |
| dec_tgt_o | output | 4 | Target ID of the winning window |
| dec_attr_o | output | 8 | Attribute of the winning window |
| dec_addr_o | output | 36 | Translated or passed-through address |

## Verification
Register reads are combinational, so the bench samples `reg_rdata_o` one time unit after it drives the offset, before the next rising edge. A decode request driven on a falling edge is captured on the following rising edge. Its result is compared on the next falling edge, exactly one cycle after the stimulus. Requests follow each other back to back. For R10, the bench drives a write and a decode in the same cycle and expects the old result. It then expects the new result from the very next request.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
  localparam int unsigned PA_W   = 36;
  localparam int unsigned GRAN_W = 16;
  localparam int unsigned PG_W   = PA_W - GRAN_W;
  localparam int unsigned SZ_W   = 32 - GRAN_W;
  localparam int unsigned HI_W   = PA_W - 32;
  localparam int unsigned TGT_W  = 4;
  localparam int unsigned ATTR_W = 8;

  typedef enum logic [1:0] {
    RK_CTRL = 2'd0,
    RK_BASE = 2'd1,
    RK_RLO  = 2'd2,
    RK_RHI  = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic              en;
    logic [TGT_W-1:0]  tgt;
    logic [ATTR_W-1:0] attr;
    logic [SZ_W-1:0]   size_m1;
    logic [PG_W-1:0]   base_pg;
    logic [PG_W-1:0]   rmp_pg;
  } win_cfg_t;
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
  import addr_win_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 20,
  parameter int unsigned NUM_REMAP = 8,
  parameter int unsigned REG_AW    = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [REG_AW-1:0]         addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  output win_cfg_t [NUM_WIN-1:0]    cfg_o
);
  localparam int unsigned WIN_W      = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int unsigned GRP_WORDS  = 4;
  localparam int unsigned PK_WORDS   = 2;
  localparam int unsigned HOLE_WORDS = 4;
  localparam int unsigned REMAP_END  = NUM_REMAP * GRP_WORDS;
  localparam int unsigned PK_START   = REMAP_END + HOLE_WORDS;
  localparam int unsigned PK_END     = PK_START + (NUM_WIN - NUM_REMAP) * PK_WORDS;

  win_cfg_t [NUM_WIN-1:0] cfg_q;
  logic [31:0] word, pk_off;
  logic        sel_vld;
  logic [WIN_W-1:0] sel_win;
  reg_kind_e   sel_kind;
  win_cfg_t    cur;
  logic        unused_wbits;

  assign unused_wbits = ^{wdata_i[3:1], wdata_i[SZ_W-1:HI_W]};

  // offset -> (window, register kind)
  always_comb begin
    word     = 32'(addr_i) >> 2;
    pk_off   = word - PK_START;
    sel_vld  = 1'b0;
    sel_win  = '0;
    sel_kind = RK_CTRL;
    if (word < REMAP_END) begin
      sel_vld  = 1'b1;
      sel_win  = WIN_W'(word >> 2);
      sel_kind = reg_kind_e'(word[1:0]);
    end else if (word >= PK_START && word < PK_END) begin
      sel_vld  = 1'b1;
      sel_win  = WIN_W'(NUM_REMAP + (pk_off >> 1));
      sel_kind = pk_off[0] ? RK_BASE : RK_CTRL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i && sel_vld) begin
      for (int unsigned i = 0; i < NUM_WIN; i++) begin
        if (sel_win == WIN_W'(i)) begin
          unique case (sel_kind)
            RK_CTRL: begin
              cfg_q[i].en      <= wdata_i[0];
              cfg_q[i].tgt     <= wdata_i[4 +: TGT_W];
              cfg_q[i].attr    <= wdata_i[8 +: ATTR_W];
              cfg_q[i].size_m1 <= wdata_i[31 -: SZ_W];
            end
            RK_BASE: cfg_q[i].base_pg <= {wdata_i[HI_W-1:0], wdata_i[31 -: SZ_W]};
            RK_RLO: if (i < NUM_REMAP) cfg_q[i].rmp_pg[SZ_W-1:0] <= wdata_i[31 -: SZ_W];
            RK_RHI: if (i < NUM_REMAP) cfg_q[i].rmp_pg[PG_W-1:SZ_W] <= wdata_i[HI_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    cur     = cfg_q[sel_win];
    if (sel_vld) begin
      unique case (sel_kind)
        RK_CTRL: rdata_o = {cur.size_m1, cur.attr, cur.tgt, 3'b000, cur.en};
        RK_BASE: rdata_o = {cur.base_pg[SZ_W-1:0], 12'h000, cur.base_pg[PG_W-1:SZ_W]};
        RK_RLO:  rdata_o = {cur.rmp_pg[SZ_W-1:0], 16'h0000};
        RK_RHI:  rdata_o = {28'h0, cur.rmp_pg[PG_W-1:SZ_W]};
        default: rdata_o = '0;
      endcase
    end
  end

  assign cfg_o = cfg_q;

  // R4: out-of-map writes leave every window untouched
  p_hole_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sel_vld) |=> $stable(cfg_q));
endmodule

// File: rtl/awd_match.sv
module awd_match
  import addr_win_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 20,
  parameter int unsigned NUM_REMAP = 8
) (
  input  win_cfg_t [NUM_WIN-1:0]         cfg_i,
  input  logic [PA_W-1:0]                addr_i,
  output logic [NUM_WIN-1:0]             hit_o,
  output logic [NUM_WIN-1:0][PA_W-1:0]   xlat_o
);
  logic [PG_W-1:0] page;
  assign page = addr_i[PA_W-1:GRAN_W];

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic [PG_W-1:0] msk;
    assign msk      = PG_W'(cfg_i[i].size_m1);
    assign hit_o[i] = cfg_i[i].en && ((page & ~msk) == cfg_i[i].base_pg);
    if (i < NUM_REMAP) begin : g_rmp
      assign xlat_o[i] = {cfg_i[i].rmp_pg | (page & msk), addr_i[GRAN_W-1:0]};
    end else begin : g_pass
      assign xlat_o[i] = addr_i;
    end
  end
endmodule

// File: rtl/awd_prio.sv
module awd_prio #(
  parameter int unsigned N = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end

  assign any_o = |req_i;

  p_gnt_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_gnt_is_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & req_i) == gnt_o);
  p_gnt_lowest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o - N'(1)) & req_i) == '0);
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
  import addr_win_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 20,
  parameter int unsigned NUM_REMAP = 8,
  parameter int unsigned REG_AW    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              dec_valid_i,
  input  logic [PA_W-1:0]   dec_addr_i,
  output logic              dec_valid_o,
  output logic              dec_hit_o,
  output logic              dec_miss_o,
  output logic [TGT_W-1:0]  dec_tgt_o,
  output logic [ATTR_W-1:0] dec_attr_o,
  output logic [PA_W-1:0]   dec_addr_o
);
  win_cfg_t [NUM_WIN-1:0]           cfg;
  logic [NUM_WIN-1:0]               hit, gnt;
  logic [NUM_WIN-1:0][PA_W-1:0]     xlat;
  logic                             any;
  logic [TGT_W-1:0]                 sel_tgt;
  logic [ATTR_W-1:0]                sel_attr;
  logic [PA_W-1:0]                  sel_addr;

  logic              valid_q, hit_q;
  logic [TGT_W-1:0]  tgt_q;
  logic [ATTR_W-1:0] attr_q;
  logic [PA_W-1:0]   addr_q;

  awd_regfile #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .REG_AW(REG_AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .cfg_o(cfg)
  );

  awd_match #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_match (
    .cfg_i(cfg), .addr_i(dec_addr_i), .hit_o(hit), .xlat_o(xlat)
  );

  awd_prio #(.N(NUM_WIN)) u_prio (
    .clk_i, .rst_ni, .req_i(hit), .gnt_o(gnt), .any_o(any)
  );

  always_comb begin
    sel_tgt  = '0;
    sel_attr = '0;
    sel_addr = dec_addr_i;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (gnt[i]) begin
        sel_tgt  = cfg[i].tgt;
        sel_attr = cfg[i].attr;
        sel_addr = xlat[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      tgt_q   <= '0;
      attr_q  <= '0;
      addr_q  <= '0;
    end else begin
      valid_q <= dec_valid_i;
      hit_q   <= dec_valid_i & any;
      tgt_q   <= dec_valid_i ? sel_tgt  : '0;
      attr_q  <= dec_valid_i ? sel_attr : '0;
      addr_q  <= dec_valid_i ? sel_addr : '0;
    end
  end

  assign dec_valid_o = valid_q;
  assign dec_hit_o   = hit_q;
  assign dec_miss_o  = valid_q & ~hit_q;
  assign dec_tgt_o   = tgt_q;
  assign dec_attr_o  = attr_q;
  assign dec_addr_o  = addr_q;

  p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i |=> dec_valid_o);
  p_hit_needs_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_hit_o |-> dec_valid_o);
  p_hit_miss_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_hit_o && dec_miss_o));
  p_miss_passthru_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && !any) |=> (dec_miss_o && dec_addr_o == $past(dec_addr_i)));
endmodule

// File: tb/addr_win_decoder_test.sv
module addr_win_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 20;
  localparam int NR = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        dec_valid_i = 1'b0;
  logic [35:0] dec_addr_i = '0;
  logic        dec_valid_o, dec_hit_o, dec_miss_o;
  logic [3:0]  dec_tgt_o;
  logic [7:0]  dec_attr_o;
  logic [35:0] dec_addr_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [31:0] m_ctrl [NW];
  logic [31:0] m_base [NW];
  logic [31:0] m_rlo  [NW];
  logic [31:0] m_rhi  [NW];

  addr_win_decoder uut (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int grp(input int w);
    return (w < NR) ? w * 16 : 'h90 + (w - NR) * 8;
  endfunction

  function automatic void map_off(input int off, output bit v, output int w, output int k);
    v = 0; w = 0; k = 0;
    if (off < NR * 16) begin
      v = 1; w = off / 16; k = (off % 16) / 4;
    end else if (off >= 'h90 && off < 'h90 + (NW - NR) * 8) begin
      v = 1; w = NR + (off - 'h90) / 8; k = ((off - 'h90) % 8) / 4;
    end
  endfunction

  function automatic logic [31:0] model_rd(input int off);
    bit v; int w, k;
    map_off(off, v, w, k);
    if (!v) return 32'h0;
    case (k)
      0: return m_ctrl[w];
      1: return m_base[w];
      2: return m_rlo[w];
      default: return m_rhi[w];
    endcase
  endfunction

  function automatic logic [50:0] model_dec(input logic [35:0] a);
    logic [19:0] page, msk, bpg, rpg;
    page = a[35:16];
    for (int w = 0; w < NW; w++) begin
      msk = {4'h0, m_ctrl[w][31:16]};
      bpg = {m_base[w][3:0], m_base[w][31:16]};
      rpg = {m_rhi[w][3:0], m_rlo[w][31:16]};
      if (m_ctrl[w][0] && ((page & ~msk) == bpg)) begin
        if (w < NR)
          return {1'b1, 1'b1, 1'b0, m_ctrl[w][7:4], m_ctrl[w][15:8], rpg | (page & msk), a[15:0]};
        else
          return {1'b1, 1'b1, 1'b0, m_ctrl[w][7:4], m_ctrl[w][15:8], a};
      end
    end
    return {1'b1, 1'b0, 1'b1, 4'h0, 8'h00, a};
  endfunction

  // called on a falling edge; returns on the next falling edge
  task automatic wr(input int off, input logic [31:0] d);
    bit v; int w, k;
    reg_we_i = 1'b1; reg_addr_i = 8'(off); reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    map_off(off, v, w, k);
    if (v) begin
      case (k)
        0: m_ctrl[w] = d & 32'hFFFF_FFF1;
        1: m_base[w] = d & 32'hFFFF_000F;
        2: m_rlo[w]  = d & 32'hFFFF_0000;
        default: m_rhi[w] = d & 32'h0000_000F;
      endcase
    end
  endtask

  task automatic rd(input int off, input string req);
    reg_addr_i = 8'(off);
    #1;
    chk(req, 64'(reg_rdata_o), 64'(model_rd(off)));
  endtask

  task automatic dec(input logic [35:0] a, input string req);
    dec_valid_i = 1'b1; dec_addr_i = a;
    @(negedge clk_i);
    chk(req, 64'({dec_valid_o, dec_hit_o, dec_miss_o, dec_tgt_o, dec_attr_o, dec_addr_o}),
        64'(model_dec(a)));
    dec_valid_i = 1'b0;
  endtask

  logic [35:0] pts [17] = '{
    36'h0_0FFF_FFFF, 36'h0_1000_0000, 36'h0_1000_FFFF, 36'h0_1001_0000,
    36'h0_10FF_FFFF, 36'h0_1100_0000, 36'h4_0010_0000, 36'h4_001F_FFFF,
    36'h4_0020_0000, 36'h4_000F_FFFF, 36'hF_FFFF_0000, 36'hF_FFFF_FFFF,
    36'hF_FFFE_FFFF, 36'h0_3000_0000, 36'h0_2001_0000, 36'h0_2000_0000,
    36'h0_0000_0000};

  initial begin
    for (int w = 0; w < NW; w++) begin
      m_ctrl[w] = '0; m_base[w] = '0; m_rlo[w] = '0; m_rhi[w] = '0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: reset state
    for (int off = 0; off < 256; off += 4) rd(off, "R1 reset read");
    dec(36'h0_1000_0000, "R1 reset miss");

    // R2 R4: distinct pattern per offset, then read back the whole map
    for (int off = 0; off < 256; off += 4) begin
      logic [7:0] o8;
      o8 = 8'(off);
      wr(off, {o8, ~o8, o8 ^ 8'h5A, ~o8 ^ 8'h3C});
    end
    for (int off = 0; off < 256; off += 4) rd(off, "R2 R4 map readback");

    // R3: all-ones shows field masks
    for (int off = 0; off < 256; off += 4) wr(off, 32'hFFFF_FFFF);
    for (int off = 0; off < 256; off += 4) rd(off, "R3 field mask");
    for (int off = 0; off < 256; off += 4) wr(off, 32'h0);

    // decode configuration
    wr(grp(0) + 4, 32'h1000_0000); wr(grp(0) + 8, 32'h2000_0000);
    wr(grp(0) + 12, 32'h3);         wr(grp(0), 32'h0000_1111);
    wr(grp(3) + 4, 32'h0010_0004); wr(grp(3) + 8, 32'h0050_0000);
    wr(grp(3), 32'h000F_2221);
    wr(grp(9) + 4, 32'h1000_0000); wr(grp(9), 32'h00FF_5551);
    wr(grp(19) + 4, 32'hFFFF_000F); wr(grp(19), 32'h0000_FFF1);
    wr(grp(12) + 4, 32'h3000_0000); wr(grp(12), 32'h0000_CCC0);
    wr(grp(5) + 4, 32'h2001_0000); wr(grp(5), 32'h0001_6661);

    // R5 R6 R7 R8: boundaries, overlap, disabled and unaligned windows
    foreach (pts[i]) dec(pts[i], "R5 R6 R7 R8 point");
    for (int k = 0; k < 64; k++)
      dec(36'h0_0FF8_0000 + 36'(k) * 36'h4_0000 + 36'(k * 'h137), "R6 R8 overlap sweep");
    for (int k = 0; k < 32; k++)
      dec(36'h4_000C_0000 + 36'(k) * 36'h1_0000 + 36'(k), "R6 R7 remap sweep");

    // R9: idle request
    dec_valid_i = 1'b0; dec_addr_i = 36'h0_1000_0000;
    @(negedge clk_i);
    chk("R9 idle", 64'({dec_valid_o, dec_hit_o, dec_miss_o, dec_tgt_o, dec_attr_o, dec_addr_o}), 64'h0);

    // R10: write and decode on the same edge see the old settings
    reg_we_i = 1'b1; reg_addr_i = 8'(grp(12)); reg_wdata_i = 32'h0000_CCC1;
    dec_valid_i = 1'b1; dec_addr_i = 36'h0_3000_0000;
    @(negedge clk_i);
    reg_we_i = 1'b0; dec_valid_i = 1'b0;
    chk("R10 same-edge old", 64'({dec_hit_o, dec_miss_o}), 64'b01);
    m_ctrl[12] = 32'h0000_CCC1;
    dec(36'h0_3000_0000, "R10 next-edge new");
    chk("R10 target", 64'(dec_tgt_o), 64'hC);

    // R5: disable by zeroing, and clearing the enable hands over to a higher window
    wr(grp(12) + 4, 32'h0); wr(grp(12), 32'h0);
    dec(36'h0_3000_0000, "R5 zeroed window");
    wr(grp(0), 32'h0000_1110);
    dec(36'h0_1000_0000, "R5 R8 enable cleared");

    // R2 R6 R7: each window alone
    for (int w = 0; w < NW; w++) begin
      logic [35:0] b, sz;
      logic [15:0] m1;
      for (int j = 0; j < NW; j++) wr(grp(j), 32'h0);
      m1 = 16'((1 << (w % 4)) - 1);
      b  = {4'h8, 8'(w + 1), 24'h0};
      sz = 36'(m1 + 1) << 16;
      wr(grp(w) + 4, {8'(w + 1), 8'h00, 12'h0, 4'h8});
      if (w < NR) begin
        wr(grp(w) + 8, 32'h7000_0000);
        wr(grp(w) + 12, 32'(w % 16));
      end
      wr(grp(w), {m1, 8'(w * 7), 4'(w), 3'b000, 1'b1});
      dec(b, "R2 R6 window base");
      dec(b + sz - 36'd1, "R6 R7 window top");
      dec(b + sz, "R6 window above");
      dec(b - 36'd1, "R6 window below");
      dec(b + 36'h1234, "R7 window offset");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule